// File: doc/BRIEF.md
# Multi-Mode External Interrupt Decoder

This block turns eight active-low external interrupt pins and one active-low non-maskable interrupt pin into a single interrupt request for a processor core. Every pin passes through a synchronizer. A mode input chooses how the eight pins are read. In dedicated mode each pin is its own source, and a per-pin control bit selects a low-level or falling-edge trigger. In expanded mode the eight pins carry one vector number, and that number is the bitwise inverse of the pin levels. In mixed mode the three upper pins act as dedicated sources and the five lower pins supply the upper bits of a vector whose low bits are fixed.

The core sees a request flag, a flag that says whether the identifier is a vector number or a pin index, and the identifier itself. A separate flag reports the non-maskable interrupt. The core acknowledges a presented edge-triggered dedicated source to clear it, and it acknowledges the non-maskable interrupt on its own input. Comparing the request against the core's current priority is left to the core.

Top module: `xint_decoder`

## Requirements
- R1: While rst_ni is low, and after reset until an input changes, req_o, vec_mode_o, nmi_o and id_o are all zero.
- R2: mode_i encodings are 00 dedicated, 01 expanded, 10 mixed. In mode 11 the eight pins are ignored and no pin request is raised.
- R3: A dedicated pin whose trig_edge_i bit is 0 is level-triggered. It is pending only while the pin is low and stops being pending once the pin has been back high for the latency in R9.
- R4: A dedicated pin whose trig_edge_i bit is 1 latches a falling edge as pending and stays pending after the pin returns high. An edge-triggered source is cleared only when ack_i is high at a rising clock edge while that pin is the one presented (req_o=1, vec_mode_o=0, id_o equal to its index). Other pending sources are unaffected.
- R5: When several dedicated sources are pending, id_o gives the highest pin index. In mixed mode a pending dedicated source is presented before the vector.
- R6: In expanded mode, when at least one pin is low, req_o=1, vec_mode_o=1 and id_o is the bitwise inverse of irq_n_i. With all pins high no request is raised.
- R7: In mixed mode, pins 7..5 behave as dedicated sources under R3/R4. The vector is {~irq_n_i[4:0], 3'b010}. It is requested only when at least one of pins 4..0 is low.
- R8: A falling edge on nmi_n_i sets nmi_o, which stays high until nmi_ack_i is high at a rising edge. While nmi_o is high, req_o is 0. A pin request that is still pending reappears after nmi_o clears.
- R9: A change on irq_n_i or nmi_n_i reaches the outputs on the third rising clock edge after it, and not on the second. An acknowledge or a mode change takes effect on the next rising edge.
- R10: An edge latch on a pin that stops being dedicated because mode_i changed is discarded, and it does not return when the pin becomes dedicated again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Pin decode mode (00 dedicated, 01 expanded, 10 mixed, 11 off) |
| trig_edge_i | input | 8 | Per-pin trigger: 1 falling edge, 0 low level |
| irq_n_i | input | 8 | External interrupt pins, active low, asynchronous |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, falling edge, asynchronous |
| ack_i | input | 1 | Acknowledge of the presented dedicated source |
| nmi_ack_i | input | 1 | Acknowledge of the non-maskable interrupt |
| req_o | output | 1 | Pin interrupt request valid |
| vec_mode_o | output | 1 | 1: id_o is a vector number, 0: id_o is a pin index |
| id_o | output | 8 | Vector number or pin index |
| nmi_o | output | 1 | Non-maskable interrupt pending |

## Verification
A pin change passes through two synchronizer flops and one pending or vector register, so its result is due just after the third rising edge. The bench drives at falling edges and samples at the falling edge after that third rising edge. For the latency check it also samples one edge earlier and expects no change yet. Acknowledges and mode changes act on the next rising edge, so they are driven at one falling edge and checked at the following one. Every table row holds its pins long enough for the new result to settle before it is compared.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic [1:0] {
    XM_DED = 2'b00,
    XM_EXP = 2'b01,
    XM_MIX = 2'b10,
    XM_OFF = 2'b11
  } xmode_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned     W       = 9,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/xint_src.sv
module xint_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  input  logic low_i,
  input  logic fall_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!en_i)    pend_q <= 1'b0;
    else if (!edge_i)  pend_q <= low_i;
    else if (fall_i)   pend_q <= 1'b1;   // new edge wins over ack
    else if (clr_i)    pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  a_r4_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && edge_i && pend_q && !clr_i) |=> pend_q);
  a_r3_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !edge_i) |=> (pend_q == $past(low_i)));
  a_r10_drop_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q);
endmodule

// File: rtl/xint_vec.sv
module xint_vec
  import xint_pkg::*;
#(
  parameter int unsigned          W       = 8,
  parameter int unsigned          MIX_DED = 3,
  parameter logic [MIX_DED-1:0]   MIX_LOW = 3'b010
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  xmode_e       mode_i,
  input  logic [W-1:0] pins_i,
  output logic         vld_o,
  output logic [W-1:0] vec_o
);
  localparam int unsigned HI_W = W - MIX_DED;

  logic         vld_d, vld_q;
  logic [W-1:0] vec_d, vec_q;
  logic [HI_W-1:0] hi;

  always_comb begin
    hi    = ~pins_i[HI_W-1:0];
    vld_d = 1'b0;
    vec_d = '0;
    unique case (mode_i)
      XM_EXP: begin
        vec_d = ~pins_i;
        vld_d = |vec_d;
      end
      XM_MIX: begin
        vld_d = |hi;
        vec_d = vld_d ? {hi, MIX_LOW} : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      vec_q <= vec_d;
    end
  end

  assign vld_o = vld_q;
  assign vec_o = vec_q;

  a_r7_mix_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(mode_i) == XM_MIX) |-> (vec_q[MIX_DED-1:0] == MIX_LOW));
  a_r6_nonzero_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (vec_q != '0));
  a_r2_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XM_OFF) |=> !vld_q);
endmodule

// File: rtl/xint_arb.sv
module xint_arb #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pend_i,
  input  logic         vld_i,
  input  logic [W-1:0] vec_i,
  input  logic         nmi_i,
  output logic         req_o,
  output logic         vec_mode_o,
  output logic [W-1:0] id_o
);
  logic         any_pend;
  logic [W-1:0] top_idx;

  always_comb begin
    top_idx = '0;
    for (int k = 0; k < W; k++)
      if (pend_i[k]) top_idx = W'(k);   // last hit = highest index
  end

  assign any_pend = |pend_i;

  always_comb begin
    req_o      = 1'b0;
    vec_mode_o = 1'b0;
    id_o       = '0;
    if (!nmi_i) begin
      if (any_pend) begin
        req_o = 1'b1;
        id_o  = top_idx;
      end else if (vld_i) begin
        req_o      = 1'b1;
        vec_mode_o = 1'b1;
        id_o       = vec_i;
      end
    end
  end
endmodule

// File: rtl/xint_decoder.sv
module xint_decoder
  import xint_pkg::*;
#(
  parameter int unsigned                NUM_PINS    = 8,
  parameter int unsigned                MIX_DED     = 3,
  parameter logic [MIX_DED-1:0]         MIX_LOW     = 3'b010,
  parameter int unsigned                SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic [NUM_PINS-1:0] trig_edge_i,
  input  logic [NUM_PINS-1:0] irq_n_i,
  input  logic                nmi_n_i,
  input  logic                ack_i,
  input  logic                nmi_ack_i,
  output logic                req_o,
  output logic                vec_mode_o,
  output logic [NUM_PINS-1:0] id_o,
  output logic                nmi_o
);
  localparam int unsigned IDW     = $clog2(NUM_PINS);
  localparam int unsigned SW      = NUM_PINS + 1;
  localparam int unsigned MIX_VEC = NUM_PINS - MIX_DED;

  xmode_e              mode;
  logic [SW-1:0]       s_cur, s_prev;
  logic [NUM_PINS-1:0] pins, fall, ded_mask, pend;
  logic                nmi_fall, nmi_q;
  logic                vec_vld;
  logic [NUM_PINS-1:0] vec_val;

  assign mode = xmode_e'(mode_i);

  xint_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nmi_n_i, irq_n_i}),
    .q_o   (s_cur),
    .prev_o(s_prev)
  );

  assign pins     = s_cur[NUM_PINS-1:0];
  assign fall     = s_prev[NUM_PINS-1:0] & ~pins;
  assign nmi_fall = s_prev[NUM_PINS] & ~s_cur[NUM_PINS];

  always_comb begin
    unique case (mode)
      XM_DED:  ded_mask = '1;
      XM_MIX:  ded_mask = {{MIX_DED{1'b1}}, {MIX_VEC{1'b0}}};
      default: ded_mask = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_src
    logic clr;
    assign clr = ack_i && req_o && !vec_mode_o && (id_o == NUM_PINS'(i));
    xint_src i_src (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ded_mask[i]),
      .edge_i(trig_edge_i[i]),
      .low_i (~pins[i]),
      .fall_i(fall[i]),
      .clr_i (clr),
      .pend_o(pend[i])
    );
  end

  xint_vec #(.W(NUM_PINS), .MIX_DED(MIX_DED), .MIX_LOW(MIX_LOW)) i_vec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .pins_i(pins),
    .vld_o (vec_vld),
    .vec_o (vec_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        nmi_q <= 1'b0;
    else if (nmi_fall)  nmi_q <= 1'b1;
    else if (nmi_ack_i) nmi_q <= 1'b0;
  end

  xint_arb #(.W(NUM_PINS)) i_arb (
    .pend_i    (pend),
    .vld_i     (vec_vld),
    .vec_i     (vec_val),
    .nmi_i     (nmi_q),
    .req_o     (req_o),
    .vec_mode_o(vec_mode_o),
    .id_o      (id_o)
  );

  assign nmi_o = nmi_q;

  a_r8_nmi_masks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> !req_o);
  a_r8_nmi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !nmi_ack_i) |=> nmi_o);
  a_r5_index_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !vec_mode_o) |-> pend[id_o[IDW-1:0]]);
  a_r5_index_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !vec_mode_o) |-> ((pend >> id_o[IDW-1:0]) == NUM_PINS'(1)));
  a_r7_mix_ded_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == XM_MIX && $past(mode) == XM_MIX && req_o && !vec_mode_o)
      |-> (id_o >= NUM_PINS'(MIX_VEC)));
  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !vec_mode_o && trig_edge_i[id_o[IDW-1:0]]
     && ded_mask[id_o[IDW-1:0]] && !fall[id_o[IDW-1:0]])
      |=> !pend[$past(id_o[IDW-1:0])]);
endmodule

// File: tb/test_xint_decoder.sv
`timescale 1ns/1ps
module test_xint_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [7:0] trig_edge_i = 8'h00;
  logic [7:0] irq_n_i = 8'hFF;
  logic       nmi_n_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       nmi_ack_i = 1'b0;
  logic       req_o, vec_mode_o, nmi_o;
  logic [7:0] id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  xint_decoder i_xint_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .trig_edge_i(trig_edge_i),
    .irq_n_i(irq_n_i), .nmi_n_i(nmi_n_i), .ack_i(ack_i), .nmi_ack_i(nmi_ack_i),
    .req_o(req_o), .vec_mode_o(vec_mode_o), .id_o(id_o), .nmi_o(nmi_o)
  );

  // {mode, pins, req, vec_mode, id}
  localparam int NV = 16;
  localparam logic [19:0] TBL [NV] = '{
    {2'b00, 8'hFF, 1'b0, 1'b0, 8'h00},
    {2'b00, 8'hFE, 1'b1, 1'b0, 8'h00},
    {2'b00, 8'h7F, 1'b1, 1'b0, 8'h07},
    {2'b00, 8'h5A, 1'b1, 1'b0, 8'h07},  // R5 several low
    {2'b00, 8'hF5, 1'b1, 1'b0, 8'h03},  // R5 several low
    {2'b01, 8'hFF, 1'b0, 1'b0, 8'h00},
    {2'b01, 8'h00, 1'b1, 1'b1, 8'hFF},
    {2'b01, 8'hA5, 1'b1, 1'b1, 8'h5A},
    {2'b01, 8'hFE, 1'b1, 1'b1, 8'h01},
    {2'b10, 8'hFF, 1'b0, 1'b0, 8'h00},
    {2'b10, 8'hE0, 1'b1, 1'b1, 8'hFA},
    {2'b10, 8'hFE, 1'b1, 1'b1, 8'h0A},
    {2'b10, 8'h7F, 1'b1, 1'b0, 8'h07},
    {2'b10, 8'hBE, 1'b1, 1'b0, 8'h06},  // R5 dedicated before vector
    {2'b10, 8'h1F, 1'b1, 1'b0, 8'h07},
    {2'b11, 8'h00, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic r, input logic vm,
                         input logic [7:0] id, input logic nm);
    chk(tag, "req_o", {31'd0, req_o}, {31'd0, r});
    chk(tag, "vec_mode_o", {31'd0, vec_mode_o}, {31'd0, vm});
    chk(tag, "id_o", {24'd0, id_o}, {24'd0, id});
    chk(tag, "nmi_o", {31'd0, nmi_o}, {31'd0, nm});
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
    end
  end

  initial begin
    // R1 reset state
    settle(2);
    chk_out("R1", 1'b0, 1'b0, 8'h00, 1'b0);
    rst_ni = 1'b1;
    settle(4);
    chk_out("R1", 1'b0, 1'b0, 8'h00, 1'b0);

    // table walk, level trigger throughout
    for (int k = 0; k < NV; k++) begin
      string tag;
      mode_i  = TBL[k][19:18];
      irq_n_i = TBL[k][17:10];
      unique case (TBL[k][19:18])
        2'b00:   tag = "R3";
        2'b01:   tag = "R6";
        2'b10:   tag = "R7";
        default: tag = "R2";
      endcase
      settle(4);
      chk_out(tag, TBL[k][9], TBL[k][8], TBL[k][7:0], 1'b0);
    end

    // R9 latency: not on 2nd edge, present on 3rd
    mode_i = 2'b00; irq_n_i = 8'hFF;
    settle(4);
    irq_n_i = 8'hF7;
    settle(2);
    chk_out("R9", 1'b0, 1'b0, 8'h00, 1'b0);
    settle(1);
    chk_out("R9", 1'b1, 1'b0, 8'h03, 1'b0);
    // R3 level drop
    irq_n_i = 8'hFF;
    settle(3);
    chk_out("R3", 1'b0, 1'b0, 8'h00, 1'b0);

    // R4 edge latch and selective ack
    trig_edge_i = 8'h14;
    settle(2);
    irq_n_i = 8'hEB;
    settle(4);
    irq_n_i = 8'hFF;
    settle(4);
    chk_out("R4", 1'b1, 1'b0, 8'h04, 1'b0);
    ack_i = 1'b1;
    settle(1);
    ack_i = 1'b0;
    chk_out("R4", 1'b1, 1'b0, 8'h02, 1'b0);
    settle(2);
    chk_out("R4", 1'b1, 1'b0, 8'h02, 1'b0);
    ack_i = 1'b1;
    settle(1);
    ack_i = 1'b0;
    chk_out("R4", 1'b0, 1'b0, 8'h00, 1'b0);

    // R8 NMI over a level request
    trig_edge_i = 8'h00;
    irq_n_i = 8'h7F;
    nmi_n_i = 1'b0;
    settle(3);
    chk_out("R8", 1'b0, 1'b0, 8'h00, 1'b1);
    nmi_n_i = 1'b1;
    settle(4);
    chk_out("R8", 1'b0, 1'b0, 8'h00, 1'b1);
    nmi_ack_i = 1'b1;
    settle(1);
    nmi_ack_i = 1'b0;
    chk_out("R8", 1'b1, 1'b0, 8'h07, 1'b0);
    irq_n_i = 8'hFF;
    settle(4);

    // R10 mode change discards edge latch
    trig_edge_i = 8'h01;
    irq_n_i = 8'hFE;
    settle(4);
    irq_n_i = 8'hFF;
    settle(4);
    chk_out("R10", 1'b1, 1'b0, 8'h00, 1'b0);
    mode_i = 2'b10;
    settle(2);
    chk_out("R10", 1'b0, 1'b0, 8'h00, 1'b0);
    mode_i = 2'b00;
    settle(2);
    chk_out("R10", 1'b0, 1'b0, 8'h00, 1'b0);

    // R7 edge source on a mixed dedicated pin
    mode_i = 2'b10;
    trig_edge_i = 8'h20;
    settle(2);
    irq_n_i = 8'hDF;
    settle(4);
    irq_n_i = 8'hFF;
    settle(4);
    chk_out("R7", 1'b1, 1'b0, 8'h05, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule